// File: doc/BRIEF.md
# External Interrupt Line Controller

This block turns up to 32 external interrupt pins into per-line interrupt requests for a processor. Each pin is first brought into the block's clock domain, then watched for the condition chosen by that line's sense field: a low level, a high level, a falling edge, a rising edge, or either edge. A detected condition sets a sticky detect bit. Software clears detect bits by writing ones to them.

A per-line enable mask, changed through separate set and clear registers, gates each detect bit onto its own request output. Software reaches everything through a 32-bit word bus that accepts one transfer per cycle. Read data returns one cycle after the read is accepted. A monitor register shows the synchronized level of every pin. Line n is always bit n in the detect, monitor, enable and request registers.

Top module: `ext_irq_ctrl`

## Requirements
- R1: After reset all enable bits, detect bits and sense fields are zero, and every `irq_o` bit is low.
- R2: Line n has a configuration word at byte offset 0x180 + 4*n. A write stores only bits [5:0] as the sense field. Bits [31:6] read back as zero.
- R3: Sense bit 0 detects a low level and bit 1 a high level. Bit 2 detects a falling edge, bit 3 a rising edge, and 0x0C detects both edges. Edges are found by comparing consecutive synchronized samples. With sense bits [3:0] at zero the line never sets its detect bit.
- R4: Writing offset 0x100 clears each detect bit whose data bit is 1 and leaves the bits written 0 unchanged. If a new event occurs on the clock edge that accepts the clear, the bit stays set.
- R5: In a level mode the detect bit is set again on every clock while the synchronized level is active, so a clear has no lasting effect until the pin goes inactive.
- R6: Writing ones to offset 0x08 sets those enable bits. Writing ones to offset 0x04 clears them. Zero bits leave the enables unchanged, and reads of either offset return the enable mask.
- R7: A read of offset 0x00 returns the detect bits ANDed with the enable bits.
- R8: `irq_o[n]` is high exactly when detect bit n and enable bit n are both set. It follows register state with no added delay.
- R9: Offset 0x104 reads the pin levels after a two-flop synchronizer. A pin change shows up in reads accepted on the third clock edge after the change, and after that edge.
- R10: `bus_ready_o` is always high. A read accepted on an edge gives `bus_rvalid_o` high for the next cycle, with data taken before that edge. Address bits [1:0] are ignored. Unmapped offsets read zero and ignore writes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Block clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| pin_i | input | NUM_LINES | Raw external interrupt pins, asynchronous |
| bus_valid_i | input | 1 | Transfer request |
| bus_ready_o | output | 1 | Transfer accepted (tied high) |
| bus_we_i | input | 1 | 1 = write, 0 = read |
| bus_addr_i | input | ADDR_W | Byte address of the register |
| bus_wdata_i | input | 32 | Write data |
| bus_rdata_o | output | 32 | Read data, valid with bus_rvalid_o |
| bus_rvalid_o | output | 1 | Read data valid, one cycle after a read |
| irq_o | output | NUM_LINES | Per-line interrupt requests |

## Verification
The assertions assume that the bus carries at most one transfer per cycle and that `bus_valid_i`, `bus_we_i`, the address and the write data are stable around the sampling edge. Pins may change at any time, because the detectors only ever see synchronized values. The stimulus drives every input on the falling clock edge and uses only word-aligned addresses. It mixes random pin patterns with random set, clear, detect-clear and configuration writes. A behavioural model predicts the request lines and every read on each clock.

// File: rtl/eirq_pkg.sv
package eirq_pkg;
  localparam int unsigned SENSE_W  = 6;
  localparam int unsigned SNS_LOW  = 0;
  localparam int unsigned SNS_HIGH = 1;
  localparam int unsigned SNS_FALL = 2;
  localparam int unsigned SNS_RISE = 3;

  localparam int unsigned OFF_REQ    = 32'h000;
  localparam int unsigned OFF_EN_CLR = 32'h004;
  localparam int unsigned OFF_EN_SET = 32'h008;
  localparam int unsigned OFF_DET    = 32'h100;
  localparam int unsigned OFF_MON    = 32'h104;
  localparam int unsigned OFF_CFG    = 32'h180;

  typedef logic [SENSE_W-1:0] sense_t;
endpackage

// File: rtl/eirq_sync.sv
module eirq_sync #(
  parameter int unsigned W      = 32,
  parameter int unsigned STAGES = 2
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [W-1:0] d_i,
  output logic [W-1:0] q_o
);
  logic [STAGES-1:0][W-1:0] stg_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      stg_q <= '0;
    end else begin
      stg_q[0] <= d_i;
      for (int s = 1; s < STAGES; s++) stg_q[s] <= stg_q[s-1];
    end
  end

  assign q_o = stg_q[STAGES-1];
endmodule

// File: rtl/eirq_line.sv
module eirq_line
  import eirq_pkg::*;
(
  input  logic   clk_i,
  input  logic   rst_ni,
  input  logic   lvl_i,
  input  sense_t sense_i,
  input  logic   clr_i,
  output logic   det_o
);
  logic prev_q;
  logic det_q;
  logic evt;
  logic unused_hi;

  assign unused_hi = ^sense_i[SENSE_W-1:4];

  always_comb begin
    evt = (sense_i[SNS_LOW]  & ~lvl_i)
        | (sense_i[SNS_HIGH] &  lvl_i)
        | (sense_i[SNS_FALL] &  prev_q & ~lvl_i)
        | (sense_i[SNS_RISE] & ~prev_q &  lvl_i);
  end

  // a fresh event outranks a clear on the same edge
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      prev_q <= 1'b0;
      det_q  <= 1'b0;
    end else begin
      prev_q <= lvl_i;
      det_q  <= evt | (det_q & ~clr_i);
    end
  end

  assign det_o = det_q;

  p_rise_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (sense_i[SNS_RISE] && lvl_i && !prev_q) |=> det_o);
  p_fall_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (sense_i[SNS_FALL] && !lvl_i && prev_q) |=> det_o);
  p_idle_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (sense_i[3:0] == 4'd0 && !det_o) |=> !det_o);
  p_w1c_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (clr_i && sense_i[3:0] == 4'd0) |=> !det_o);
  p_high_hold_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (sense_i[SNS_HIGH] && lvl_i) |=> det_o);
  p_low_hold_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (sense_i[SNS_LOW] && !lvl_i) |=> det_o);
endmodule

// File: rtl/eirq_regs.sv
module eirq_regs
  import eirq_pkg::*;
#(
  parameter int unsigned N      = 32,
  parameter int unsigned ADDR_W = 12
) (
  input  logic                clk_i,
  input  logic                rst_ni,
  input  logic                valid_i,
  input  logic                we_i,
  input  logic [ADDR_W-1:0]   addr_i,
  input  logic [31:0]         wdata_i,
  output logic                ready_o,
  output logic [31:0]         rdata_o,
  output logic                rvalid_o,
  input  logic [N-1:0]        det_i,
  input  logic [N-1:0]        mon_i,
  output logic [N-1:0]        en_o,
  output sense_t [N-1:0]      sense_o,
  output logic [N-1:0]        clr_o
);
  localparam int unsigned WORD_W = ADDR_W - 2;
  localparam int unsigned IDX_W  = (N > 1) ? $clog2(N) : 1;
  localparam logic [WORD_W-1:0] W_REQ    = WORD_W'(OFF_REQ >> 2);
  localparam logic [WORD_W-1:0] W_EN_CLR = WORD_W'(OFF_EN_CLR >> 2);
  localparam logic [WORD_W-1:0] W_EN_SET = WORD_W'(OFF_EN_SET >> 2);
  localparam logic [WORD_W-1:0] W_DET    = WORD_W'(OFF_DET >> 2);
  localparam logic [WORD_W-1:0] W_MON    = WORD_W'(OFF_MON >> 2);
  localparam logic [WORD_W-1:0] W_CFG    = WORD_W'(OFF_CFG >> 2);
  localparam logic [WORD_W-1:0] W_NLINE  = WORD_W'(N);

  logic [WORD_W-1:0] word;
  logic [WORD_W-1:0] cfg_off;
  logic [IDX_W-1:0]  cfg_idx;
  logic              cfg_hit;
  logic              wr_en;
  logic              rd_en;
  logic [31:0]       rd_data;
  logic [N-1:0]      en_q;
  sense_t [N-1:0]    sense_q;
  logic [31:0]       rdata_q;
  logic              rvalid_q;
  logic              unused_lsb;

  assign unused_lsb = ^addr_i[1:0];
  assign word       = addr_i[ADDR_W-1:2];
  assign wr_en      = valid_i & we_i;
  assign rd_en      = valid_i & ~we_i;
  assign cfg_off    = word - W_CFG;
  assign cfg_hit    = (word >= W_CFG) && (cfg_off < W_NLINE);
  assign cfg_idx    = cfg_off[IDX_W-1:0];

  assign clr_o = (wr_en && word == W_DET) ? wdata_i[N-1:0] : '0;

  always_comb begin
    rd_data = '0;
    if (word == W_REQ)                          rd_data = 32'(det_i & en_q);
    else if (word == W_EN_CLR || word == W_EN_SET) rd_data = 32'(en_q);
    else if (word == W_DET)                     rd_data = 32'(det_i);
    else if (word == W_MON)                     rd_data = 32'(mon_i);
    else if (cfg_hit)                           rd_data = 32'(sense_q[cfg_idx]);
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      en_q     <= '0;
      rdata_q  <= '0;
      rvalid_q <= 1'b0;
    end else begin
      rvalid_q <= rd_en;
      if (rd_en) rdata_q <= rd_data;
      if (wr_en && word == W_EN_SET)      en_q <= en_q | wdata_i[N-1:0];
      else if (wr_en && word == W_EN_CLR) en_q <= en_q & ~wdata_i[N-1:0];
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      sense_q <= '0;
    end else if (wr_en && cfg_hit) begin
      sense_q[cfg_idx] <= wdata_i[SENSE_W-1:0];
    end
  end

  assign ready_o  = 1'b1;
  assign rdata_o  = rdata_q;
  assign rvalid_o = rvalid_q;
  assign en_o     = en_q;
  assign sense_o  = sense_q;

  p_en_set_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_en && word == W_EN_SET) |=> ((en_o & $past(wdata_i[N-1:0])) == $past(wdata_i[N-1:0])));
  p_en_clr_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_en && word == W_EN_CLR) |=> ((en_o & $past(wdata_i[N-1:0])) == '0));
  p_rvalid_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rd_en |=> rvalid_o);
  p_no_rvalid_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !rd_en |=> !rvalid_o);
  p_cfg_keep_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !wr_en |=> $stable(sense_o));
endmodule

// File: rtl/ext_irq_ctrl.sv
module ext_irq_ctrl
  import eirq_pkg::*;
#(
  parameter int unsigned NUM_LINES   = 32,
  parameter int unsigned ADDR_W      = 12,
  parameter int unsigned SYNC_STAGES = 2
) (
  input  logic                 clk_i,
  input  logic                 rst_ni,
  input  logic [NUM_LINES-1:0] pin_i,
  input  logic                 bus_valid_i,
  output logic                 bus_ready_o,
  input  logic                 bus_we_i,
  input  logic [ADDR_W-1:0]    bus_addr_i,
  input  logic [31:0]          bus_wdata_i,
  output logic [31:0]          bus_rdata_o,
  output logic                 bus_rvalid_o,
  output logic [NUM_LINES-1:0] irq_o
);
  localparam logic [ADDR_W-1:0] A_EN_CLR = ADDR_W'(OFF_EN_CLR);

  logic [NUM_LINES-1:0]   sync_lvl;
  logic [NUM_LINES-1:0]   det;
  logic [NUM_LINES-1:0]   en;
  logic [NUM_LINES-1:0]   clr;
  sense_t [NUM_LINES-1:0] sense;

  eirq_sync #(.W(NUM_LINES), .STAGES(SYNC_STAGES)) u_sync (
    .clk_i,
    .rst_ni,
    .d_i (pin_i),
    .q_o (sync_lvl)
  );

  eirq_regs #(.N(NUM_LINES), .ADDR_W(ADDR_W)) u_regs (
    .clk_i,
    .rst_ni,
    .valid_i  (bus_valid_i),
    .we_i     (bus_we_i),
    .addr_i   (bus_addr_i),
    .wdata_i  (bus_wdata_i),
    .ready_o  (bus_ready_o),
    .rdata_o  (bus_rdata_o),
    .rvalid_o (bus_rvalid_o),
    .det_i    (det),
    .mon_i    (sync_lvl),
    .en_o     (en),
    .sense_o  (sense),
    .clr_o    (clr)
  );

  for (genvar g = 0; g < NUM_LINES; g++) begin : g_line
    eirq_line u_line (
      .clk_i,
      .rst_ni,
      .lvl_i   (sync_lvl[g]),
      .sense_i (sense[g]),
      .clr_i   (clr[g]),
      .det_o   (det[g])
    );
  end

  assign irq_o = det & en;

  p_all_off_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (bus_valid_i && bus_we_i && bus_addr_i == A_EN_CLR && bus_wdata_i == 32'hFFFF_FFFF)
    |=> (irq_o == '0));
endmodule

// File: tb/ext_irq_ctrl_bench.sv
`timescale 1ns/1ps
module ext_irq_ctrl_bench;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [31:0] pins = '0;
  logic        valid = 1'b0;
  logic        we = 1'b0;
  logic [11:0] addr = '0;
  logic [31:0] wdata = '0;
  logic        ready;
  logic [31:0] rdata;
  logic        rvalid;
  logic [31:0] irq;

  int    checks = 0;
  int    fails  = 0;
  string phase  = "R1";
  bit    chk_on = 1'b0;

  bit [31:0] m_s1, m_s2, m_prev, m_det, m_en, m_rdata, m_ev, m_clr;
  bit [5:0]  m_sense [32];
  bit        m_rvalid;

  always #4 clk = ~clk;

  ext_irq_ctrl u_ext_irq_ctrl (
    .clk_i        (clk),
    .rst_ni       (rst_n),
    .pin_i        (pins),
    .bus_valid_i  (valid),
    .bus_ready_o  (ready),
    .bus_we_i     (we),
    .bus_addr_i   (addr),
    .bus_wdata_i  (wdata),
    .bus_rdata_o  (rdata),
    .bus_rvalid_o (rvalid),
    .irq_o        (irq)
  );

  function automatic bit [31:0] mread(logic [11:0] a);
    if (a == 12'h000) return m_det & m_en;
    if (a == 12'h004 || a == 12'h008) return m_en;
    if (a == 12'h100) return m_det;
    if (a == 12'h104) return m_s2;
    if (a >= 12'h180 && a <= 12'h1FC) return {26'b0, m_sense[(a - 12'h180) >> 2]};
    return '0;
  endfunction

  // behavioural reference, updated on each rising edge
  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_s1 = '0; m_s2 = '0; m_prev = '0; m_det = '0; m_en = '0;
      m_rvalid = 1'b0; m_rdata = '0;
      for (int i = 0; i < 32; i++) m_sense[i] = '0;
    end else begin
      m_ev = '0;
      for (int i = 0; i < 32; i++) begin
        if (m_sense[i][0] && !m_s2[i]) m_ev[i] = 1'b1;
        if (m_sense[i][1] &&  m_s2[i]) m_ev[i] = 1'b1;
        if (m_sense[i][2] &&  m_prev[i] && !m_s2[i]) m_ev[i] = 1'b1;
        if (m_sense[i][3] && !m_prev[i] &&  m_s2[i]) m_ev[i] = 1'b1;
      end
      m_rvalid = valid && !we;
      if (m_rvalid) m_rdata = mread(addr);
      m_clr = (valid && we && addr == 12'h100) ? wdata : '0;
      m_det = m_ev | (m_det & ~m_clr);
      if (valid && we) begin
        if (addr == 12'h004) m_en = m_en & ~wdata;
        if (addr == 12'h008) m_en = m_en | wdata;
        if (addr >= 12'h180 && addr <= 12'h1FC) m_sense[(addr - 12'h180) >> 2] = wdata[5:0];
      end
      m_prev = m_s2;
      m_s2   = m_s1;
      m_s1   = pins;
    end
  end

  task automatic check(string tag, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  always @(negedge clk) begin
    if (chk_on) begin
      check("R8 irq_o", irq, m_det & m_en);
      check("R10 rvalid", 32'(rvalid), 32'(m_rvalid));
      if (m_rvalid) check({phase, " rdata"}, rdata, m_rdata);
    end
  end

  task automatic bus_wr(logic [11:0] a, logic [31:0] d);
    valid = 1'b1; we = 1'b1; addr = a; wdata = d;
    @(negedge clk);
    valid = 1'b0; we = 1'b0;
  endtask

  task automatic bus_rd(logic [11:0] a, output logic [31:0] d);
    valid = 1'b1; we = 1'b0; addr = a;
    @(negedge clk);
    valid = 1'b0;
    d = rdata;
  endtask

  task automatic rd_chk(string tag, logic [11:0] a, logic [31:0] exp);
    logic [31:0] d;
    bus_rd(a, d);
    check(tag, d, exp);
  endtask

  task automatic idle(int n);
    repeat (n) @(negedge clk);
  endtask

  function automatic logic [11:0] pick_addr(int sel);
    case (sel)
      0: return 12'h000;
      1: return 12'h004;
      2: return 12'h008;
      3: return 12'h100;
      4: return 12'h104;
      5: return 12'h00C;
      default: return 12'(12'h180 + 4 * $urandom_range(0, 31));
    endcase
  endfunction

  task automatic summary();
    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    fails++;
    $display("FAIL R10 watchdog: actual timeout expected completion");
    summary();
    $finish;
  end

  initial begin
    int r;
    logic [31:0] code;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    chk_on = 1'b1;

    phase = "R1";
    check("R1 irq after reset", irq, 32'h0);
    rd_chk("R1 enable", 12'h004, 32'h0);
    rd_chk("R1 detect", 12'h100, 32'h0);
    rd_chk("R1 sense", 12'h180, 32'h0);

    phase = "R6";
    bus_wr(12'h008, 32'hF0F0_000F);
    rd_chk("R6 set", 12'h004, 32'hF0F0_000F);
    bus_wr(12'h004, 32'h0000_0003);
    rd_chk("R6 clear", 12'h008, 32'hF0F0_000C);
    bus_wr(12'h004, 32'hFFFF_FFFF);
    rd_chk("R6 clear all", 12'h004, 32'h0);

    phase = "R2";
    bus_wr(12'h194, 32'hFFFF_FFC8);
    rd_chk("R2 low bits only", 12'h194, 32'h0000_0008);
    bus_wr(12'h194, 32'h0);
    rd_chk("R2 rewrite", 12'h194, 32'h0);

    phase = "R10";
    rd_chk("R10 unmapped read", 12'h00C, 32'h0);
    bus_wr(12'h00C, 32'hFFFF_FFFF);
    rd_chk("R10 unmapped write ignored", 12'h004, 32'h0);
    rd_chk("R10 beyond config", 12'h200, 32'h0);

    phase = "R9";
    pins = 32'hA5A5_0000;
    idle(4);
    rd_chk("R9 monitor", 12'h104, 32'hA5A5_0000);
    pins = 32'h0000_FFFF;
    rd_chk("R9 edge1 old", 12'h104, 32'hA5A5_0000);
    rd_chk("R9 edge2 old", 12'h104, 32'hA5A5_0000);
    rd_chk("R9 edge3 new", 12'h104, 32'h0000_FFFF);
    pins = 32'h0;
    idle(4);

    phase = "R3";
    bus_wr(12'h180, 32'h08);
    bus_wr(12'h184, 32'h04);
    bus_wr(12'h188, 32'h0C);
    bus_wr(12'h18C, 32'h02);
    bus_wr(12'h190, 32'h01);
    bus_wr(12'h198, 32'h00);
    bus_wr(12'h008, 32'h5F);
    idle(4);
    rd_chk("R5 low level detect", 12'h100, 32'h10);
    rd_chk("R7 request status", 12'h000, 32'h10);
    check("R8 irq line4", irq, 32'h10);
    bus_wr(12'h100, 32'h10);
    rd_chk("R5 low level reasserts", 12'h100, 32'h10);

    pins = 32'h5F;
    idle(4);
    rd_chk("R3 rising edges", 12'h100, 32'h1D);
    bus_wr(12'h100, 32'h5F);
    rd_chk("R5 high level reasserts", 12'h100, 32'h08);
    pins = 32'h0;
    idle(4);
    rd_chk("R3 falling edges", 12'h100, 32'h1E);
    bus_wr(12'h100, 32'h5F);
    rd_chk("R4 w1c", 12'h100, 32'h10);

    phase = "R8";
    bus_wr(12'h004, 32'h10);
    check("R8 gated off", irq, 32'h0);
    rd_chk("R7 masked", 12'h000, 32'h0);
    rd_chk("R8 detect kept", 12'h100, 32'h10);

    phase = "R4";
    pins = 32'h1;
    idle(2);
    bus_wr(12'h100, 32'h1);
    rd_chk("R4 edge wins over clear", 12'h100, 32'h11);
    bus_wr(12'h100, 32'h1);
    rd_chk("R4 later clear", 12'h100, 32'h10);

    phase = "R3";
    for (int k = 0; k < 1500; k++) begin
      if (k % 3 == 0) pins = $urandom;
      r = $urandom_range(0, 9);
      case (r)
        0: bus_wr(12'h008, $urandom);
        1: bus_wr(12'h004, $urandom);
        2: bus_wr(12'h100, $urandom);
        3: begin
          case ($urandom_range(0, 6))
            0: code = 32'h00;
            1: code = 32'h01;
            2: code = 32'h02;
            3: code = 32'h04;
            4: code = 32'h08;
            5: code = 32'h0C;
            default: code = $urandom;
          endcase
          bus_wr(12'(12'h180 + 4 * $urandom_range(0, 31)), code);
        end
        4, 5, 6: begin
          logic [31:0] d;
          bus_rd(pick_addr($urandom_range(0, 6)), d);
        end
        default: idle(1);
      endcase
    end

    idle(2);
    chk_on = 1'b0;
    summary();
    $finish;
  end
endmodule